// File: doc/BRIEF.md
# Alternating Dual Half-Rate Multiplier

This unit multiplies one pair of unsigned operands per clock cycle and returns the low word of each product. It never stalls and takes a new operation on every cycle. No single multiplier inside it has to finish within one clock period. A phase bit toggles on every cycle and steers each operation to one of two multiplier lanes in turn. A lane keeps its operands in its registers for two cycles, so its multiply is a two-cycle path. Each lane then registers its own result.

The output selector always picks the lane whose result has just been registered. Products therefore leave in the order the operands arrived, with a fixed latency of four cycles. This matches the depth of a four-stage arithmetic pipeline. The lane is chosen by cycle parity alone, so gaps in the input stream do not change the timing.

Top module: `altmul_dual`

## Requirements
- R1: When `in_valid` is high in cycle n, `out_valid` is high in cycle n+4. An input is sampled at a clock edge, and its result appears after the third edge that follows.
- R2: Whenever `out_valid` is high, `out_p` equals the low W bits of the unsigned product of the `in_a` and `in_b` that were presented four cycles earlier. This includes wraparound, for example all-ones times all-ones gives 1.
- R3: The unit takes operands on every cycle, including long back-to-back runs. Each accepted operation produces exactly one result, in input order, and none is dropped.
- R4: When `in_valid` is low in cycle n, `out_valid` is low in cycle n+4. A gap in the input stream appears as a gap in the output stream, whatever the pattern of gaps.
- R5: After a synchronous reset (`rst_n` low at a clock edge), `out_valid` stays low until a valid operation presented after reset has come through the four cycles of latency.
- R6: An operation presented while `rst_n` is low is discarded and never produces a result. Operations still in flight when reset is applied are also discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operand pair is present this cycle |
| in_a | input | W | First operand, unsigned |
| in_b | input | W | Second operand, unsigned |
| out_valid | output | 1 | A product is present this cycle |
| out_p | output | W | Low W bits of the product |

## Verification
The multiply is driven with uninterrupted back-to-back random operands. Because the two lanes then always alternate, a swapped lane or a misordered merge shows up as a wrong product. Sparse random valids and regular patterns (one valid then one gap, two valids then two gaps) separate lane choice by cycle parity from lane choice by valid count, and they show whether gaps travel through with the data. Directed operands (zero, one, all-ones, top bit set) check truncation to the low word. A reset applied during a run checks that work still in flight is discarded, together with any input presented during reset.

// File: rtl/altmul_pkg.sv
// Shared constants for the alternating dual multiplier.
// Assumes exactly two lanes; the phase bit indexes them directly.
package altmul_pkg;
    localparam int unsigned ALTMUL_LANES   = 2;
    localparam int unsigned ALTMUL_LATENCY = 4;
endpackage

// File: rtl/altmul_steer.sv
// Input stage and lane phase. Registers the incoming operation and
// toggles a phase bit every cycle, independent of valid.
// Assumes: the registered operation is taken by the lane whose id
// differs from the phase value before the next edge.
module altmul_steer #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         st_valid,
    output logic [W-1:0] st_a,
    output logic [W-1:0] st_b,
    output logic         phase
);
    // Phase toggle: lane selection depends only on cycle parity.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Input register: one operation captured per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_a     <= '0;
            st_b     <= '0;
        end else begin
            st_valid <= in_valid;
            st_a     <= in_a;
            st_b     <= in_b;
        end
    end
endmodule

// File: rtl/altmul_lane.sv
// One half-rate multiplier lane. It takes operands on every other
// edge, holds them for two cycles, and on its next turn registers the
// low word of their product. Assumes the product path is constrained
// as a two-cycle path.
module altmul_lane #(
    parameter int unsigned W       = 36,
    parameter int unsigned LANE_ID = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase,
    input  logic         st_valid,
    input  logic [W-1:0] st_a,
    input  logic [W-1:0] st_b,
    output logic         res_valid,
    output logic [W-1:0] res_p
);
    localparam logic MY_PHASE = 1'(LANE_ID);

    logic         turn;
    logic         op_valid;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [W-1:0] prod_lo;

    // Turn decode: this lane acts when the phase is the other value.
    always_comb turn = (phase != MY_PHASE);

    // Two-cycle multiply of the held operands, low word kept.
    always_comb prod_lo = op_a * op_b;

    // Operand hold: refreshed only on this lane's turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_a     <= '0;
            op_b     <= '0;
        end else if (turn) begin
            op_valid <= st_valid;
            op_a     <= st_a;
            op_b     <= st_b;
        end
    end

    // Result register: captures the previous turn's product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_p     <= '0;
        end else if (turn) begin
            res_valid <= op_valid;
            res_p     <= prod_lo;
        end
    end
endmodule

// File: rtl/altmul_merge.sv
// In-order merge. Selects the lane whose result register was just
// refreshed, which is the lane numbered by the current phase.
// Assumes lane results change only on their own turn.
module altmul_merge #(
    parameter int unsigned W     = 36,
    parameter int unsigned LANES = 2
) (
    input  logic                    phase,
    input  logic [LANES-1:0]        res_valid,
    input  logic [LANES-1:0][W-1:0] res_p,
    output logic                    out_valid,
    output logic [W-1:0]            out_p
);
    // Output select by phase.
    always_comb begin
        out_valid = res_valid[phase];
        out_p     = res_p[phase];
    end
endmodule

// File: rtl/altmul_dual.sv
// Top of the alternating dual half-rate multiplier. One operation per
// cycle in, low-word products out in order after four cycles.
// Assumes unsigned operands and a synchronous active-low reset.
module altmul_dual #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_p
);
    import altmul_pkg::*;
    localparam int unsigned LANES = ALTMUL_LANES;

    logic                    phase;
    logic                    st_valid;
    logic [W-1:0]            st_a;
    logic [W-1:0]            st_b;
    logic [LANES-1:0]        res_valid;
    logic [LANES-1:0][W-1:0] res_p;

    altmul_steer #(.W(W)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .st_valid (st_valid),
        .st_a     (st_a),
        .st_b     (st_b),
        .phase    (phase)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        altmul_lane #(.W(W), .LANE_ID(g)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .phase     (phase),
            .st_valid  (st_valid),
            .st_a      (st_a),
            .st_b      (st_b),
            .res_valid (res_valid[g]),
            .res_p     (res_p[g])
        );
    end

    altmul_merge #(.W(W), .LANES(LANES)) u_merge (
        .phase     (phase),
        .res_valid (res_valid),
        .res_p     (res_p),
        .out_valid (out_valid),
        .out_p     (out_p)
    );
endmodule

// Port-level checker for altmul_dual. It counts edges since reset so
// that no property looks back past the reset.
module altmul_dual_chk #(
    parameter int unsigned W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic [W-1:0] out_p
);
    logic [2:0] since_rst;

    // Saturating count of edges with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_rst <= '0;
        else if (since_rst < 4) since_rst <= since_rst + 3'd1;
    end

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4 && $past(in_valid, 4)) |-> out_valid);

    // R2
    prod_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4 && out_valid) |->
        (out_p == W'($past(in_a, 4) * $past(in_b, 4))));

    // R4
    bubble_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4 && !$past(in_valid, 4)) |-> !out_valid);

    // R5
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3) |-> !out_valid);
endmodule

bind altmul_dual altmul_dual_chk #(.W(W)) u_altmul_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_p     (out_p)
);

// File: tb/tb_altmul_dual.sv
module tb_altmul_dual;
    localparam int unsigned W        = 36;
    localparam time         CLK_HALF = 5ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_p;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    logic         hv [4];
    logic [W-1:0] hp [4];

    altmul_dual #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_p(out_p)
    );

    always #(CLK_HALF) clk = ~clk;

    function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        logic [2*W-1:0] full;
        full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        return full[W-1:0];
    endfunction

    function automatic logic [W-1:0] rnd_w();
        return {$urandom(), $urandom()} & {W{1'b1}};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: check outputs against the input of four cycles ago,
    // then drive this cycle's input (discarded when rst low, R6).
    task automatic step(logic r, logic v, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        check(hv[3] ? cur_req : "R4", W'(out_valid), W'(hv[3]));
        if (hv[3]) check("R2", out_p, hp[3]);
        for (int i = 3; i > 0; i--) begin
            hv[i] = hv[i-1];
            hp[i] = hp[i-1];
        end
        hv[0] = r & v;
        hp[0] = ref_mul(a, b);
        if (!r) for (int i = 0; i < 4; i++) hv[i] = 1'b0;
        rst_n = r; in_valid = v; in_a = a; in_b = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240224));
        for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hp[i] = '0; end
        // R6: valid operations offered during reset are discarded.
        cur_req = "R6";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, rnd_w(), rnd_w());
        // R5: nothing valid until a post-reset operation arrives.
        cur_req = "R5";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, '0);
        @(negedge clk);
        check("R5", W'(out_valid), '0);
        // R2: directed corner operands, wraparound of the low word.
        cur_req = "R1";
        step(1'b1, 1'b1, {W{1'b1}}, {W{1'b1}});
        step(1'b1, 1'b1, '0, rnd_w());
        step(1'b1, 1'b1, W'(1), {W{1'b1}});
        step(1'b1, 1'b1, {1'b1, {(W-1){1'b0}}}, W'(2));
        step(1'b1, 1'b1, {1'b1, {(W-1){1'b0}}}, W'(3));
        step(1'b1, 1'b1, W'(36'h0_FFFF_FFFF), W'(36'h0_FFFF_FFFF));
        // R3: long back-to-back random run.
        cur_req = "R3";
        for (int i = 0; i < 400; i++) step(1'b1, 1'b1, rnd_w(), rnd_w());
        // R4: sparse random valids.
        cur_req = "R1";
        for (int i = 0; i < 300; i++) step(1'b1, 1'(($urandom() % 3) == 0), rnd_w(), rnd_w());
        // R4: valid/gap alternation, then pairs of valids and gaps.
        for (int i = 0; i < 40; i++) step(1'b1, 1'(i % 2), rnd_w(), rnd_w());
        for (int i = 0; i < 40; i++) step(1'b1, 1'((i / 2) % 2), rnd_w(), rnd_w());
        // R6: reset in the middle of a stream drops in-flight work.
        cur_req = "R3";
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, rnd_w(), rnd_w());
        cur_req = "R6";
        step(1'b0, 1'b1, rnd_w(), rnd_w());
        step(1'b0, 1'b1, rnd_w(), rnd_w());
        cur_req = "R5";
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, rnd_w(), rnd_w());
        cur_req = "R3";
        for (int i = 0; i < 50; i++) step(1'b1, 1'b1, rnd_w(), rnd_w());
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, '0, '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule